// File: doc/BRIEF.md
# Masked-Write Control Register Bank for a Camera Receive PHY

This block holds the static and sequencing controls of a serial camera receive PHY: per-lane enables and mode forces, the turnaround and clock-polarity controls, and the bit-banged test port used to program the PHY's internal settings. Software reaches it over a simple single-cycle request bus. Every write word carries its own per-bit write enables. The upper half-word is a mask for the lower half-word, so one field can change without a read-modify-write. Several agents can also share one register without racing.

Three control words and one read-only status word are mapped at word addresses 0 to 3. The status word returns the 8-bit result that the PHY's test port drives back. Any other address is rejected with a one-cycle error flag and changes nothing. Read data and the error flag are registered and appear one clock after the request. Control outputs change on the same edge that accepts the write.

Top module: `dphy_ctl_regbank`

## Requirements
- R1: While `rst_n` is low at a clock edge, all control outputs, `rsp_rdata` and `rsp_err` become zero.
- R2: On an accepted write to a control word, stored bit i takes `req_wdata[i]` only when `req_wdata[i+16]` is 1. Otherwise it keeps its value.
- R3: A read of a control word returns its stored low half-word in `rsp_rdata[15:0]` one cycle later. `rsp_rdata[31:16]` is always zero, and bits with no function read as zero.
- R4: Word address 0 (lane word): `lane_en` = bits 3:0, `force_rx` = bits 7:4, `force_stop` = bits 11:8, `turn_dis` = bits 15:12.
- R5: Word address 1 (turnaround word): `turn_req` = bits 3:0, `clk_inv[0]` = bit 10, `clk_inv[1]` = bit 11. Bits 9:4 and 15:12 have no function.
- R6: Word address 2 (test-port word): `test_din` = bits 7:0, `test_en` = bit 8, `test_clk` = bit 9, `test_clr` = bit 10. Bits 15:11 have no function.
- R7: A read of word address 3 returns `test_dout` in bits 7:0 and zero above, sampled at the request edge. Writes to address 3 are ignored and raise no error.
- R8: A request to a word address above 3 raises `rsp_err` for exactly the next cycle. It leaves every control word unchanged. A read there returns zero.
- R9: `rsp_err` is low in any cycle that does not follow an accepted request to an unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write mask [31:16] and write value [15:0] |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | One-cycle unmapped-address flag |
| test_dout | input | 8 | Test-port result from the PHY |
| lane_en | output | 4 | Per-lane enable |
| force_rx | output | 4 | Per-lane force receive mode |
| force_stop | output | 4 | Per-lane force stop state |
| turn_dis | output | 4 | Per-lane turnaround disable |
| turn_req | output | 4 | Per-lane turnaround request |
| clk_inv | output | 2 | Receive clock inversion selects |
| test_din | output | 8 | Test-port data/code |
| test_en | output | 1 | Test-port code/data select |
| test_clk | output | 1 | Test-port strobe |
| test_clr | output | 1 | Test-port clear |

## Verification
The bench targets masks that cover only part of a field, an all-zero mask carrying non-zero data, and writes of all ones to words that have non-functional bits. A design that ignored the mask would overwrite the neighbouring fields. A design that stored every bit would read back ones where zeros are required. It also writes to the status address, which must neither store anything nor flag an error. Finally it sends requests to unmapped addresses, checks that the flag drops on the next idle cycle, and reads back every word afterwards. A decoder that aliased high addresses onto low ones would corrupt a control word there.

// File: rtl/dphy_ctl_pkg.sv
// Shared constants for the PHY control register bank.
// Assumes a 32-bit bus word whose upper half is a per-bit write mask.
package dphy_ctl_pkg;
    localparam int HALF     = 16;
    localparam int WORD     = 2 * HALF;
    localparam int NUM_CTRL = 3;
    localparam int STAT_W   = 8;

    // Word slots; the status slot follows the control words.
    typedef enum logic [1:0] {
        SLOT_LANE = 2'd0,
        SLOT_TURN = 2'd1,
        SLOT_TEST = 2'd2,
        SLOT_STAT = 2'd3
    } slot_e;

    // Bits that exist in each control word.
    localparam logic [HALF-1:0] IMPL_LANE = 16'hFFFF;
    localparam logic [HALF-1:0] IMPL_TURN = 16'h0C0F;
    localparam logic [HALF-1:0] IMPL_TEST = 16'h07FF;

    // Returns the implemented-bit mask of control slot s.
    function automatic logic [HALF-1:0] impl_mask(input int s);
        case (s)
            0:       return IMPL_LANE;
            1:       return IMPL_TURN;
            2:       return IMPL_TEST;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/hwm_decode.sv
// Address decoder: turns one bus request into per-word write strobes,
// a read slot index and an unmapped-address indication.
// Assumes slots 0..NUM_CTRL-1 are control words, slot NUM_CTRL is status.
module hwm_decode #(
    parameter int ADDR_W   = 4,
    parameter int NUM_CTRL = 3
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [NUM_CTRL-1:0] ctrl_wr,
    output logic              rd_ok,
    output logic              bad
);
    localparam int TOP_SLOT = NUM_CTRL;

    logic mapped;

    // Mapped if the address falls on a control word or the status word.
    always_comb mapped = (32'(req_addr) <= TOP_SLOT);

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_wr
        // Write strobe for control word g.
        always_comb ctrl_wr[g] = req_valid && req_write && (32'(req_addr) == g);
    end

    // Read accepted at a mapped address.
    always_comb rd_ok = req_valid && !req_write && mapped;
    // Any request at an unmapped address.
    always_comb bad = req_valid && !mapped;
endmodule

// File: rtl/hwm_reg.sv
// One masked-write control half-word. Bit i follows wdata[i] only when
// wdata[i+HALF] is set; bits outside IMPL are never stored.
module hwm_reg #(
    parameter int              HALF = 16,
    parameter logic [HALF-1:0] IMPL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2*HALF-1:0] wdata,
    output logic [HALF-1:0]   q
);
    logic [HALF-1:0] en;

    // Effective per-bit enable: bus mask restricted to implemented bits.
    always_comb en = wdata[2*HALF-1:HALF] & IMPL;

    // Storage with per-bit update.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= (q & ~en) | (wdata[HALF-1:0] & en);
    end
endmodule

// File: rtl/hwm_rdmux.sv
// Read multiplexer: picks a control half-word or the status byte by slot
// and zero-extends to the bus width. Assumes the slot is already mapped.
module hwm_rdmux #(
    parameter int ADDR_W   = 4,
    parameter int NUM_CTRL = 3,
    parameter int HALF     = 16,
    parameter int STAT_W   = 8
) (
    input  logic [NUM_CTRL*HALF-1:0] ctrl_flat,
    input  logic [STAT_W-1:0]        status,
    input  logic [ADDR_W-1:0]        slot,
    output logic [2*HALF-1:0]        rd_word
);
    // Select the addressed word.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_CTRL; i++)
            if (32'(slot) == i) rd_word[HALF-1:0] = ctrl_flat[i*HALF +: HALF];
        if (32'(slot) == NUM_CTRL) rd_word[STAT_W-1:0] = status;
    end
endmodule

// File: rtl/dphy_ctl_regbank.sv
// Control register bank for a camera receive PHY. Three masked-write
// control words and one read-only status word on a single-cycle bus;
// read data and the error flag are registered one cycle after the request.
// Assumes a caller that holds a request for one cycle only.
module dphy_ctl_regbank
    import dphy_ctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD-1:0]   req_wdata,
    output logic [WORD-1:0]   rsp_rdata,
    output logic              rsp_err,
    input  logic [STAT_W-1:0] test_dout,
    output logic [3:0]        lane_en,
    output logic [3:0]        force_rx,
    output logic [3:0]        force_stop,
    output logic [3:0]        turn_dis,
    output logic [3:0]        turn_req,
    output logic [1:0]        clk_inv,
    output logic [7:0]        test_din,
    output logic              test_en,
    output logic              test_clk,
    output logic              test_clr
);
    logic [NUM_CTRL-1:0]      ctrl_wr;
    logic                     rd_ok;
    logic                     bad;
    logic [NUM_CTRL*HALF-1:0] ctrl_flat;
    logic [WORD-1:0]          rd_word;
    logic [HALF-1:0]          w_lane, w_turn, w_test;

    hwm_decode #(.ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .ctrl_wr   (ctrl_wr),
        .rd_ok     (rd_ok),
        .bad       (bad)
    );

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_reg
        hwm_reg #(.HALF(HALF), .IMPL(impl_mask(g))) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (ctrl_wr[g]),
            .wdata (req_wdata),
            .q     (ctrl_flat[g*HALF +: HALF])
        );
    end

    hwm_rdmux #(.ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .HALF(HALF), .STAT_W(STAT_W)) u_mux (
        .ctrl_flat (ctrl_flat),
        .status    (test_dout),
        .slot      (req_addr),
        .rd_word   (rd_word)
    );

    // Registered response: read data on mapped reads, zero on bad reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_err <= bad;
            if (rd_ok)    rsp_rdata <= rd_word;
            else if (bad && !req_write) rsp_rdata <= '0;
        end
    end

    // Unpack the stored words.
    always_comb begin
        w_lane = ctrl_flat[SLOT_LANE*HALF +: HALF];
        w_turn = ctrl_flat[SLOT_TURN*HALF +: HALF];
        w_test = ctrl_flat[SLOT_TEST*HALF +: HALF];
    end

    // Field fan-out to the PHY.
    always_comb begin
        lane_en    = w_lane[3:0];
        force_rx   = w_lane[7:4];
        force_stop = w_lane[11:8];
        turn_dis   = w_lane[15:12];
        turn_req   = w_turn[3:0];
        clk_inv    = w_turn[11:10];
        test_din   = w_test[7:0];
        test_en    = w_test[8];
        test_clk   = w_test[9];
        test_clr   = w_test[10];
    end
endmodule

// File: rtl/dphy_ctl_regbank_chk.sv
// Protocol checker for the PHY control register bank, attached by bind.
module dphy_ctl_regbank_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic [7:0]        test_dout,
    input logic [3:0]        lane_en,
    input logic [3:0]        force_rx,
    input logic [3:0]        force_stop,
    input logic [3:0]        turn_dis,
    input logic [3:0]        turn_req,
    input logic [1:0]        clk_inv,
    input logic [7:0]        test_din,
    input logic              test_en,
    input logic              test_clk,
    input logic              test_clr
);
    logic bad_req;
    logic [35:0] all_ctrl;

    always_comb bad_req  = req_valid && (32'(req_addr) > 3);
    always_comb all_ctrl = {lane_en, force_rx, force_stop, turn_dis, turn_req,
                            clk_inv, test_din, test_en, test_clk, test_clr};

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (all_ctrl == '0 && rsp_rdata == '0 && !rsp_err));

    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_wdata[31:16] == '0) |=> $stable(all_ctrl));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[31:16] == '0);

    assert_status_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && 32'(req_addr) == 3) |=>
        (rsp_rdata == {24'h0, $past(test_dout)}));

    assert_status_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && 32'(req_addr) == 3) |=> ($stable(all_ctrl) && !rsp_err));

    assert_bad_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |=> (rsp_err && $stable(all_ctrl)));

    assert_no_spurious_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_req |=> !rsp_err);
endmodule

bind dphy_ctl_regbank dphy_ctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .test_dout(test_dout), .lane_en(lane_en),
    .force_rx(force_rx), .force_stop(force_stop), .turn_dis(turn_dis),
    .turn_req(turn_req), .clk_inv(clk_inv), .test_din(test_din),
    .test_en(test_en), .test_clk(test_clk), .test_clr(test_clr)
);

// File: tb/dphy_ctl_regbank_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module dphy_ctl_regbank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int NVEC       = 20;
    localparam int WDOG       = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [7:0]  test_dout = 8'hA5;
    logic [3:0]  lane_en, force_rx, force_stop, turn_dis, turn_req;
    logic [1:0]  clk_inv;
    logic [7:0]  test_din;
    logic        test_en, test_clk, test_clr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dphy_ctl_regbank #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .test_dout(test_dout), .lane_en(lane_en),
        .force_rx(force_rx), .force_stop(force_stop), .turn_dis(turn_dis),
        .turn_req(turn_req), .clk_inv(clk_inv), .test_din(test_din),
        .test_en(test_en), .test_clk(test_clk), .test_clr(test_clr)
    );

    // {write, addr, wdata, expected read, expected err}
    localparam logic [69:0] VEC [NVEC] = '{
        {1'b1, 4'h0, 32'hFFFF_1234, 32'h0000_0000, 1'b0}, // R2 full write
        {1'b0, 4'h0, 32'h0,         32'h0000_1234, 1'b0}, // R3
        {1'b1, 4'h0, 32'h00F0_00A0, 32'h0000_0000, 1'b0}, // R2 one field
        {1'b0, 4'h0, 32'h0,         32'h0000_12A4, 1'b0},
        {1'b1, 4'h0, 32'h0000_FFFF, 32'h0000_0000, 1'b0}, // R2 empty mask
        {1'b0, 4'h0, 32'h0,         32'h0000_12A4, 1'b0},
        {1'b1, 4'h1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}, // R5
        {1'b0, 4'h1, 32'h0,         32'h0000_0C0F, 1'b0},
        {1'b1, 4'h1, 32'h0800_0000, 32'h0000_0000, 1'b0},
        {1'b0, 4'h1, 32'h0,         32'h0000_040F, 1'b0},
        {1'b1, 4'h2, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}, // R6
        {1'b0, 4'h2, 32'h0,         32'h0000_07FF, 1'b0},
        {1'b1, 4'h2, 32'h0300_00C3, 32'h0000_0000, 1'b0},
        {1'b0, 4'h2, 32'h0,         32'h0000_04FF, 1'b0},
        {1'b1, 4'h3, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}, // R7 ignored write
        {1'b0, 4'h3, 32'h0,         32'h0000_00A5, 1'b0}, // R7
        {1'b1, 4'h7, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1}, // R8
        {1'b0, 4'h0, 32'h0,         32'h0000_12A4, 1'b0}, // R8 unchanged, R9
        {1'b0, 4'h9, 32'h0,         32'h0000_0000, 1'b1}, // R8 bad read
        {1'b0, 4'h1, 32'h0,         32'h0000_040F, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge; return at the next falling edge.
    task automatic access(input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ctrl", {lane_en, force_rx, force_stop, turn_dis, turn_req, clk_inv,
                          test_din, test_en, test_clk, test_clr}, 32'h0);
        check("R1 rsp", {rsp_rdata[30:0], rsp_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][69], VEC[i][68:65], VEC[i][64:33]);
            if (!VEC[i][69]) check($sformatf("R3/R7/R8 read vec %0d", i), rsp_rdata, VEC[i][32:1]);
            check($sformatf("R8/R9 err vec %0d", i), {31'h0, rsp_err}, {31'h0, VEC[i][0]});
        end

        // R4: lane word 0x12A4
        check("R4 fields", {16'h0, turn_dis, force_stop, force_rx, lane_en}, 32'h0000_12A4);
        // R5: turnaround word 0x040F
        check("R5 fields", {26'h0, clk_inv, turn_req}, {26'h0, 2'b01, 4'hF});
        // R6: test word 0x04FF
        check("R6 fields", {21'h0, test_clr, test_clk, test_en, test_din}, 32'h0000_04FF);

        // R9: flag drops on the idle cycle after a bad request
        access(1'b1, 4'hF, 32'hFFFF_0000);
        check("R8 err", {31'h0, rsp_err}, 32'h1);
        @(negedge clk);
        check("R9 err idle", {31'h0, rsp_err}, 32'h0);

        // R7: status follows the live input
        test_dout = 8'h3C;
        access(1'b0, 4'h3, 32'h0);
        check("R7 status", rsp_rdata, 32'h0000_003C);

        // R2: single bit set in lane word (bit 15)
        access(1'b1, 4'h0, 32'h8000_8000);
        check("R2 bit15", {16'h0, turn_dis, force_stop, force_rx, lane_en}, 32'h0000_92A4);

        // R1: mid-run reset clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", {lane_en, force_rx, force_stop, turn_dis, turn_req, clk_inv,
                              test_din, test_en, test_clk, test_clr}, 32'h0);
        rst_n = 1'b1;
        access(1'b0, 4'h2, 32'h0);
        check("R1 read after reset", rsp_rdata, 32'h0);

        finish_run();
    end
endmodule